// File: doc/BRIEF.md
# Priority Masked Port Shedding

This block sheds load quickly when the main power supply is overloaded. An external shutdown pin is brought into the clock domain by a two-flop synchronizer and then qualified by a host-programmable polarity bit. When the qualified input becomes active, every port that is configured as low priority receives a one-cycle power-off command. High-priority ports keep their power and their settings.

Each port that is shed also loses its detection-enable and classification-enable bits. The port therefore stays off until the host writes those bits again. Shedding acts on both the edge and the level of the input. The edge sheds every low-priority port. While the input stays active, any low-priority port that the host re-enables is shed again on the next cycle.

The path from a pin change to the power-off command is three clock edges. At 250 MHz that is 12 ns, well inside a 6.5 µs shedding budget.

Top module: `shed_top`

## Requirements
- R1: After reset, `pwrOff`, `detEn` and `clsEn` are all zero, and the shutdown polarity is active-low. A pin held high during and after reset causes no shed.
- R2: A change of the shutdown pin that sets up before clock edge k reaches the shedding logic through two synchronizer flops. The resulting power-off pulse appears after edge k+2. That is three cycles, far below the 1625-cycle budget at 250 MHz.
- R3: When `polWrEn` is 1 at an edge, the polarity register loads `polWrVal`. A value of 1 means active-high and 0 means active-low. A polarity change that makes the current synchronized pin level active counts as an activation.
- R4: On the cycle after the qualified input becomes active, `pwrOff[i]` is 1 for every port with `prioHigh[i]` = 0. This holds whether or not that port's enables were set. The pulse lasts one cycle.
- R5: A port with `prioHigh[i]` = 1 never receives `pwrOff[i]`, and shedding never changes its enables.
- R6: In the cycle where `pwrOff[i]` is 1, `detEn[i]` and `clsEn[i]` are both 0.
- R7: A cleared enable bit stays 0 until a host write (`hostWrEn` = 1) sets it. Holding the input active with no write produces no further power-off pulses.
- R8: While the input stays active, a low-priority port is shed again one cycle after the host sets either of its enables. The enables are therefore visible as 1 for exactly one cycle.
- R9: If a host write that sets a low-priority port's enables coincides with that port being shed, the shed wins. The port's enables end up 0.
- R10: While the input is inactive, a host write loads `hostDetWr` and `hostClsWr` into `detEn` and `clsEn` on the next edge, and `pwrOff` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shedPinRaw | input | 1 | Unsynchronized shutdown pin |
| polWrEn | input | 1 | Write strobe for the polarity register |
| polWrVal | input | 1 | Polarity to load: 1 active-high, 0 active-low |
| prioHigh | input | NUM_PORTS | Per-port priority, 1 = high priority (never shed) |
| hostWrEn | input | 1 | Host write strobe for both enable registers |
| hostDetWr | input | NUM_PORTS | Detection-enable write data |
| hostClsWr | input | NUM_PORTS | Classification-enable write data |
| pwrOff | output | NUM_PORTS | One-cycle power-off command per port |
| detEn | output | NUM_PORTS | Current detection-enable bits |
| clsEn | output | NUM_PORTS | Current classification-enable bits |

## Verification
The assertions assume two things about the inputs. First, the priority vector seen on the cycle before a power-off is the one that decided it. Second, the enables only rise through a host write. The stimulus meets both conditions because it changes inputs only just after a clock edge and drives no other path into the enable registers.

The random phase holds the pin steady for runs of many cycles and only occasionally rewrites the priority and polarity. This makes activation edges, held-active periods with re-enabling writes, and coinciding write and shed cycles all occur frequently. Directed cases cover the exact pin-to-pulse latency, the polarity flip, and a write that collides with a shed.

// File: rtl/shed_pkg.sv
package shed_pkg;
  // Strobes from the control side to the per-port datapath.
  typedef struct packed {
    logic shedRise;  // qualified input became active this cycle
    logic shedHold;  // qualified input is active this cycle
  } shed_strobe_t;
endpackage

// File: rtl/shed_ctrl.sv
module shed_ctrl
  import shed_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         shedPinRaw,
  input  logic         polWrEn,
  input  logic         polWrVal,
  output shed_strobe_t strb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic polActHigh;
  logic activeNow;
  logic activePrev;

  // Synchronizer resets to the idle level of the default (active-low) polarity.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ      <= '1;
      polActHigh <= 1'b0;
      activePrev <= 1'b0;
    end else begin
      syncQ      <= {syncQ[SYNC_STAGES-2:0], shedPinRaw};
      if (polWrEn) polActHigh <= polWrVal;
      activePrev <= activeNow;
    end
  end

  always_comb begin
    activeNow     = polActHigh ? syncQ[SYNC_STAGES-1] : ~syncQ[SYNC_STAGES-1];
    strb.shedHold = activeNow;
    strb.shedRise = activeNow & ~activePrev;
  end

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shedRise |=> !strb.shedRise);
endmodule

// File: rtl/shed_datapath.sv
module shed_datapath
  import shed_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  shed_strobe_t         strb,
  input  logic [NUM_PORTS-1:0] prioHigh,
  input  logic                 hostWrEn,
  input  logic [NUM_PORTS-1:0] hostDetWr,
  input  logic [NUM_PORTS-1:0] hostClsWr,
  output logic [NUM_PORTS-1:0] pwrOff,
  output logic [NUM_PORTS-1:0] detEn,
  output logic [NUM_PORTS-1:0] clsEn
);
  logic [NUM_PORTS-1:0] shedNow;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb
      shedNow[p] = ~prioHigh[p] &
                   (strb.shedRise | (strb.shedHold & (detEn[p] | clsEn[p])));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pwrOff[p] <= 1'b0;
        detEn[p]  <= 1'b0;
        clsEn[p]  <= 1'b0;
      end else begin
        pwrOff[p] <= shedNow[p];
        if (shedNow[p]) begin
          detEn[p] <= 1'b0;
          clsEn[p] <= 1'b0;
        end else if (hostWrEn) begin
          detEn[p] <= hostDetWr[p];
          clsEn[p] <= hostClsWr[p];
        end
      end
    end
  end

  // R4
  low_prio_shed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shedRise |=> ((pwrOff & ~$past(prioHigh)) == ~$past(prioHigh)));
  // R5
  high_prio_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrOff & $past(prioHigh)) == '0));
  // R6
  shed_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrOff & (detEn | clsEn)) == '0));
  // R7
  no_self_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostWrEn |=> (((detEn & ~$past(detEn)) | (clsEn & ~$past(clsEn))) == '0));
  // R10
  idle_no_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shedHold |=> (pwrOff == '0));
endmodule

// File: rtl/shed_top.sv
module shed_top
  import shed_pkg::*;
#(
  parameter int NUM_PORTS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 shedPinRaw,
  input  logic                 polWrEn,
  input  logic                 polWrVal,
  input  logic [NUM_PORTS-1:0] prioHigh,
  input  logic                 hostWrEn,
  input  logic [NUM_PORTS-1:0] hostDetWr,
  input  logic [NUM_PORTS-1:0] hostClsWr,
  output logic [NUM_PORTS-1:0] pwrOff,
  output logic [NUM_PORTS-1:0] detEn,
  output logic [NUM_PORTS-1:0] clsEn
);
  shed_strobe_t strb;

  shed_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .shedPinRaw(shedPinRaw),
    .polWrEn(polWrEn), .polWrVal(polWrVal), .strb(strb)
  );

  shed_datapath #(.NUM_PORTS(NUM_PORTS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .prioHigh(prioHigh),
    .hostWrEn(hostWrEn), .hostDetWr(hostDetWr), .hostClsWr(hostClsWr),
    .pwrOff(pwrOff), .detEn(detEn), .clsEn(clsEn)
  );
endmodule

// File: tb/shed_top_tb.sv
module shed_top_tb_top;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shedPinRaw = 1'b1;
  logic polWrEn = 1'b0, polWrVal = 1'b0;
  logic [N-1:0] prioHigh = '0;
  logic hostWrEn = 1'b0;
  logic [N-1:0] hostDetWr = '0, hostClsWr = '0;
  logic [N-1:0] pwrOff, detEn, clsEn;

  int vecCnt = 0, errCnt = 0, cyc = 0;
  bit done = 0;

  // reference state built from the requirements
  logic mS1, mS2, mPol, mPrev;
  logic [N-1:0] mOff, mDet, mCls;

  always #2 clk = ~clk;

  shed_top #(.NUM_PORTS(N)) dut_i (
    .clk(clk), .rstN(rstN), .shedPinRaw(shedPinRaw),
    .polWrEn(polWrEn), .polWrVal(polWrVal), .prioHigh(prioHigh),
    .hostWrEn(hostWrEn), .hostDetWr(hostDetWr), .hostClsWr(hostClsWr),
    .pwrOff(pwrOff), .detEn(detEn), .clsEn(clsEn)
  );

  function automatic logic [N-1:0] shedSet(input logic act, input logic rise,
      input logic [N-1:0] pr, input logic [N-1:0] d, input logic [N-1:0] c);
    return ~pr & ({N{rise}} | ({N{act}} & (d | c)));
  endfunction

  task automatic modelReset();
    mS1 = 1; mS2 = 1; mPol = 0; mPrev = 0;
    mOff = '0; mDet = '0; mCls = '0;
  endtask

  task automatic modelEdge();
    logic act, rise;
    logic [N-1:0] sh;
    act  = mPol ? mS2 : ~mS2;
    rise = act & ~mPrev;
    sh   = shedSet(act, rise, prioHigh, mDet, mCls);
    mOff = sh;
    for (int i = 0; i < N; i++) begin
      if (sh[i]) begin mDet[i] = 0; mCls[i] = 0; end
      else if (hostWrEn) begin mDet[i] = hostDetWr[i]; mCls[i] = hostClsWr[i]; end
    end
    mS2 = mS1; mS1 = shedPinRaw; mPrev = act;
    if (polWrEn) mPol = polWrVal;
  endtask

  task automatic check(input string req);
    vecCnt++;
    if (pwrOff !== mOff || detEn !== mDet || clsEn !== mCls) begin
      errCnt++;
      $display("FAIL %s cyc %0d: off/det/cls = %h/%h/%h expected %h/%h/%h",
               req, cyc, pwrOff, detEn, clsEn, mOff, mDet, mCls);
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    modelEdge();
    #1;
    cyc++;
    check(req);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    modelReset();
    check("R1 reset");
    step("R1 idle pin high");
    step("R1 idle pin high");

    // R10: enable all ports while idle
    prioHigh = 8'h0F;
    hostWrEn = 1; hostDetWr = '1; hostClsWr = 8'hA5;
    step("R10 write idle");
    hostWrEn = 0;
    step("R10 no pulse");

    // R2: pin low, active-low default; pulse after third edge
    shedPinRaw = 0;
    step("R2 sync stage 1");
    step("R2 sync stage 2");
    step("R2 R4 R5 R6 shed pulse");
    if (pwrOff !== 8'hF0) begin
      errCnt++; $display("FAIL R4 direct: pwrOff %h expected f0", pwrOff);
    end
    vecCnt++;
    step("R4 pulse single cycle");
    repeat (4) step("R7 held active no write");

    // R8: re-enable low-priority port while held active
    hostWrEn = 1; hostDetWr = 8'h30; hostClsWr = 8'h00;
    step("R8 reenable visible");
    hostWrEn = 0;
    step("R8 shed again");
    step("R8 settled");

    // R9: release, then write colliding with a new rise
    shedPinRaw = 1;
    repeat (4) step("R10 released");
    shedPinRaw = 0;
    step("R9 sync");
    hostWrEn = 1; hostDetWr = '1; hostClsWr = '1;
    step("R9 sync 2");
    step("R9 collision shed wins");
    hostWrEn = 0;
    step("R9 after");

    // R3: switch to active-high with pin high
    shedPinRaw = 1;
    repeat (3) step("R3 prep");
    polWrEn = 1; polWrVal = 1;
    hostWrEn = 1; hostDetWr = '1; hostClsWr = '1;
    step("R3 polarity write");
    polWrEn = 0; hostWrEn = 0;
    step("R3 polarity shed");
    step("R3 after");

    // random phase
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(39) == 0) shedPinRaw = ~shedPinRaw;
      hostWrEn = ($urandom_range(5) == 0);
      hostDetWr = N'($urandom); hostClsWr = N'($urandom);
      if ($urandom_range(49) == 0) prioHigh = N'($urandom);
      polWrEn = ($urandom_range(299) == 0); polWrVal = $urandom_range(1);
      step("R4 R5 R8 R9 random");
    end
    finishRun();
  end
endmodule